// File: doc/BRIEF.md
# Sequential Booth Signed Multiplier

This block multiplies two signed two's-complement operands over a fixed number of clock cycles. A one-cycle start pulse captures a multiplicand and a multiplier. On each following cycle the block looks at one multiplier bit together with the bit to its right. Based on that pair it adds the multiplicand to the running partial product, subtracts it, or leaves the partial product alone. The combined partial-product and multiplier register then shifts one place to the right, with the sign preserved.

Negative operands need no conversion before the multiply or correction after it. When the last step finishes, the double-width product is written to two result registers: an upper-half register and a lower-half register. A done flag is raised for a single cycle. The result registers keep their value until the next multiply completes, so a consumer can read them whenever it likes.

Top module: `seq_booth_mult`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy_o and done_o are 0 and hi_o and lo_o are 0.
- R2: A start_i pulse while busy_o is 0 captures the operands, and busy_o reads 1 in the cycle after that clock edge.
- R3: done_o is 1 for exactly one cycle. That cycle follows the WIDTH-th (32nd) rising edge after the edge that accepted start_i. busy_o is 0 in that same cycle, and done_o is 0 in every cycle before it.
- R4: When done_o is 1, {hi_o, lo_o} equals the signed product of mcand_i and mplier_i as a 64-bit two's-complement value. hi_o holds bits 63..32 and lo_o holds bits 31..0.
- R5: At each step the pair (current multiplier bit, bit to its right) selects the action. Pair 10 subtracts the multiplicand. Pair 01 adds it. Pairs 00 and 11 leave the partial product unchanged. An all-ones multiplier therefore yields the negated multiplicand.
- R6: The bit to the right of multiplier bit 0 is taken as 0 at the first step, so a multiplier of 1 returns the multiplicand unchanged.
- R7: The extreme operands give exact results with no wrap, including (-2^31)·(-2^31) = 2^62 and (-2^31)·(2^31-1).
- R8: hi_o and lo_o change only at the completion edge. They keep their values after done_o falls and throughout the next multiply, until that multiply completes.
- R9: A start_i pulse while busy_o is 1 is ignored. The running multiply finishes at its original time with its original operands.
- R10: A zero in either operand gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted when idle |
| mcand_i | input | 32 | Signed multiplicand |
| mplier_i | input | 32 | Signed multiplier |
| busy_o | output | 1 | A multiply is in progress |
| done_o | output | 1 | One-cycle completion flag |
| hi_o | output | 32 | Upper half of the product |
| lo_o | output | 32 | Lower half of the product |

## Verification
busy_o is due one edge after the accepting edge. done_o and the product are due exactly 32 edges after it. The bench drives start_i on a falling edge and counts falling edges from there. It samples busy_o after the first edge and done_o after each of the 32 edges, so an early, late or stretched done pulse is caught. The product is compared at the done cycle and again one cycle later. The previous product is compared mid-way through the next multiply, which exercises the hold rule.

// File: rtl/booth_pkg.sv
package booth_pkg;

    localparam int unsigned DEF_WIDTH = 32;

    typedef enum logic [1:0] {
        BOOTH_NONE = 2'd0,
        BOOTH_ADD  = 2'd1,
        BOOTH_SUB  = 2'd2
    } booth_op_e;

    // Recode the pair (current bit, bit to its right) into an action.
    function automatic booth_op_e booth_decode(input logic cur, input logic prev);
        booth_op_e op;
        case ({cur, prev})
            2'b10:   op = BOOTH_SUB;   // run of ones begins
            2'b01:   op = BOOTH_ADD;   // run of ones ends
            default: op = BOOTH_NONE;  // 00 or inside a run
        endcase
        return op;
    endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_e op
);
    always_comb op = booth_decode(cur_bit, prev_bit);
endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic [WIDTH:0]   acc,
    input  logic [WIDTH-1:0] mcand,
    input  booth_op_e        op,
    output logic [WIDTH:0]   sum
);
    logic [WIDTH:0] mext;

    always_comb begin
        mext = {mcand[WIDTH-1], mcand};
        case (op)
            BOOTH_ADD: sum = acc + mext;
            BOOTH_SUB: sum = acc - mext;
            default:   sum = acc;
        endcase
    end
endmodule

// File: rtl/booth_seq_ctrl.sv
module booth_seq_ctrl
    import booth_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int unsigned CNT_W = $clog2(WIDTH + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    logic             done_q;

    assign load = start && !busy_q;
    assign last = busy_q && (cnt_q == CNT_W'(1));
    assign busy = busy_q;
    assign done = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= last;
            if (load) begin
                cnt_q  <= CNT_W'(WIDTH);
                busy_q <= 1'b1;
            end else if (busy_q) begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (last) busy_q <= 1'b0;
            end
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy_q) |=> busy_q);

    // R9
    busy_count_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last) |=> (busy_q && cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

// File: rtl/seq_booth_mult.sv
module seq_booth_mult
    import booth_pkg::*;
#(
    parameter int unsigned WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    logic             load, last;
    logic [WIDTH:0]   acc_q;
    logic [WIDTH-1:0] q_q;
    logic             qprev_q;
    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] hi_q, lo_q;

    booth_op_e        op;
    logic [WIDTH:0]   sum;
    logic [WIDTH:0]   acc_sh;
    logic [WIDTH-1:0] q_sh;

    booth_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .load  (load),
        .last  (last),
        .busy  (busy_o),
        .done  (done_o)
    );

    booth_recode u_rec (
        .cur_bit  (q_q[0]),
        .prev_bit (qprev_q),
        .op       (op)
    );

    booth_addsub #(.WIDTH(WIDTH)) u_as (
        .acc   (acc_q),
        .mcand (mcand_q),
        .op    (op),
        .sum   (sum)
    );

    // Arithmetic right shift of {sum, q} by one place.
    always_comb begin
        acc_sh = {sum[WIDTH], sum[WIDTH:1]};
        q_sh   = {sum[0], q_q[WIDTH-1:1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            q_q     <= '0;
            qprev_q <= 1'b0;
            mcand_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
        end else if (load) begin
            acc_q   <= '0;
            q_q     <= mplier_i;
            qprev_q <= 1'b0;
            mcand_q <= mcand_i;
        end else if (busy_o) begin
            acc_q   <= acc_sh;
            q_q     <= q_sh;
            qprev_q <= q_q[0];
            if (last) begin
                hi_q <= acc_sh[WIDTH-1:0];
                lo_q <= q_sh;
            end
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // R3
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !last |=> ($stable(hi_q) && $stable(lo_q)));

    // R5
    skip_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && q_q[0] == qprev_q) |-> (sum == acc_q));
endmodule

// File: tb/sim_seq_booth_mult.sv
module sim_seq_booth_mult;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [31:0] mcand_i = '0;
    logic [31:0] mplier_i = '0;
    logic        busy_o, done_o;
    logic [31:0] hi_o, lo_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [63:0] prev_p = '0;
    bit          have_prev = 0;

    always #2.5 clk = ~clk;

    seq_booth_mult u0 (
        .clk(clk), .rst(rst), .start_i(start_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i),
        .busy_o(busy_o), .done_o(done_o), .hi_o(hi_o), .lo_o(lo_o)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // pairs {multiplicand, multiplier}
    localparam logic [63:0] VEC [12] = '{
        {32'd1,          32'd1},
        {32'hFFFFFFFF,   32'hFFFFFFFF},
        {32'd7,          32'hFFFFFFFD},
        {32'hFFFFFFF9,   32'd3},
        {32'hAAAAAAAA,   32'h55555555},
        {32'h12345678,   32'h9ABCDEF0},
        {32'h7FFFFFFF,   32'h7FFFFFFF},
        {32'h80000000,   32'h00000001},
        {32'h80000000,   32'hFFFFFFFF},
        {32'hFFFFFFFF,   32'h7FFFFFFF},
        {32'h0000FFFF,   32'hFFFF0000},
        {32'hDEADBEEF,   32'h0BADF00D}
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b,
                       input bit inject, input string tag);
        logic signed [63:0] e;
        bit early;
        e = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
        early = 0;
        @(negedge clk);
        mcand_i = a; mplier_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R2", 64'(busy_o), 64'd1);
        for (int k = 1; k <= 32; k++) begin
            @(negedge clk);
            if (inject && k == 4) begin
                start_i = 1'b1; mcand_i = ~a; mplier_i = b ^ 32'h0F0F0F0F;
            end
            if (inject && k == 5) start_i = 1'b0;
            if (k < 32 && done_o) early = 1;
            if (k == 10 && have_prev)
                chk({hi_o, lo_o} == prev_p, "R8", {hi_o, lo_o}, prev_p);
        end
        chk(!early && done_o && !busy_o, "R3", {62'd0, early, done_o}, 64'd1);
        chk({hi_o, lo_o} == e, tag, {hi_o, lo_o}, e);
        @(negedge clk);
        chk(!done_o, "R3", 64'(done_o), 64'd0);
        chk({hi_o, lo_o} == e, "R8", {hi_o, lo_o}, e);
        prev_p = e;
        have_prev = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({busy_o, done_o} == 2'b00 && hi_o == 0 && lo_o == 0, "R1",
            {hi_o, lo_o}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk({busy_o, done_o} == 2'b00 && hi_o == 0 && lo_o == 0, "R1",
            {hi_o, lo_o}, 64'd0);

        for (int i = 0; i < 12; i++)
            run(VEC[i][63:32], VEC[i][31:0], 1'b0, "R4");

        run(32'h80000000, 32'h80000000, 1'b0, "R7");
        run(32'h80000000, 32'h7FFFFFFF, 1'b0, "R7");
        run(32'h12345678, 32'hFFFFFFFF, 1'b0, "R5");
        run(32'hFFFF1234, 32'h00000001, 1'b0, "R6");
        run(32'd0, 32'h87654321, 1'b0, "R10");
        run(32'h87654321, 32'd0, 1'b0, "R10");
        run(32'h00C0FFEE, 32'hFFFFEDCB, 1'b1, "R9");

        for (int i = 0; i < 20; i++)
            run($urandom, $urandom, 1'b0, "R4");

        // idle hold after completion
        repeat (5) @(negedge clk);
        chk({hi_o, lo_o} == prev_p && !done_o, "R8", {hi_o, lo_o}, prev_p);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule